// File: doc/BRIEF.md
# Butterfly and Inverse Butterfly Bit Permuter

This block rearranges the bits of a WIDTH-bit word (WIDTH a power of two) through staged swap networks. Each network has lg(WIDTH) stages. A stage is a row of WIDTH/2 two-input switch pairs, and each pair either passes its two bits straight through or exchanges them under one control bit. The forward (butterfly) network pairs bits that lie far apart first and then halves the pairing distance at each stage. The inverse network runs the same distances in the opposite order, from 1 upward.

A two-bit opcode chooses the forward network, the inverse network, the two in series (forward, then inverse), or a plain pass. Each network has its own control word of lg(WIDTH) × WIDTH/2 bits. The series mode can reach any of the WIDTH! orderings of the input bits. The control bits for a given target ordering are worked out outside this block. The result is captured in an output register, and a valid flag follows the request by one clock.

Top module: `bfperm_unit`

## Requirements
- R1: In forward stage s (s = 1..lg WIDTH), bit i is paired with bit i + WIDTH/2^s, where i is the lower index. Slice s of `fwd_cfg` is bits (s-1)·WIDTH/2 up to s·WIDTH/2−1. Bit j of that slice drives the j-th pair, with pairs counted in ascending order of their lower index, and a 1 swaps the pair. With every control bit set, the word is reversed end to end.
- R2: In inverse stage s, bit i is paired with bit i + 2^(s−1), using slice s of `inv_cfg` with the same pair numbering and swap sense as R1.
- R3: The opcode `op` selects the operation: 2'b00 runs the forward network, 2'b01 the inverse network, 2'b10 the forward network followed by the inverse network, and 2'b11 passes `data_in` through unchanged.
- R4: An all-zero control word makes either network the identity, so with both words zero every opcode returns `data_in`.
- R5: With opcode 2'b10 and `inv_cfg` slice s equal to `fwd_cfg` slice lg(WIDTH)+1−s for every s, the result equals `data_in`.
- R6: A request with `in_valid` high at a rising edge appears on `data_out` after that edge. `out_valid` is high in exactly the cycle after each accepted request.
- R7: While `in_valid` is low, `data_out` keeps its value, whatever the other inputs do.
- R8: While `rst_n` is low at a rising edge, `data_out` and `out_valid` clear to zero, even if `in_valid` is high.
- R9: Every result is a rearrangement of the input, so the number of ones is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; loads the result register |
| op | input | 2 | Operation select (R3 encoding) |
| data_in | input | WIDTH | Word to permute |
| fwd_cfg | input | lg(WIDTH)·WIDTH/2 | Forward network stage controls, slice s at the s-th group of WIDTH/2 bits |
| inv_cfg | input | lg(WIDTH)·WIDTH/2 | Inverse network stage controls, same layout |
| out_valid | output | 1 | Result valid, one cycle after the request |
| data_out | output | WIDTH | Registered permuted word |

## Verification
The bench builds the block with WIDTH = 16, which gives four stages per network and 32 control bits per network. At this size, every control bit of both networks can be driven alone, and the pair it swaps can be compared against a reference model written from the pairing rules. Random control words in the series mode then exercise the interplay of all eight stages. The mirrored-control undo, the all-ones reversal and the register timing are also checked at this width.

// File: rtl/bfperm_pkg.sv
// Package: shared types for the butterfly permuter.
// Assumes nothing beyond a two-bit operation select.
package bfperm_pkg;

    // Operation select encoding, fixed by the block's requirements.
    typedef enum logic [1:0] {
        OP_FWD  = 2'b00,
        OP_INV  = 2'b01,
        OP_BOTH = 2'b10,
        OP_PASS = 2'b11
    } perm_op_e;

endpackage

// File: rtl/bfperm_stage.sv
// Module: one row of WIDTH/2 swap/pass switch pairs.
// Pairs bits DIST apart. Pair j has its lower index at
// (j / DIST) * 2 * DIST + j % DIST, so pairs are numbered in
// ascending order of their lower index. swap[j] = 1 exchanges the pair.
// Assumes WIDTH is a power of two and DIST is a power of two below WIDTH.
module bfperm_stage #(
    parameter int WIDTH = 32,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0]   stg_in,
    input  logic [WIDTH/2-1:0] swap,
    output logic [WIDTH-1:0]   stg_out
);

    localparam int HALF = WIDTH / 2;

    // One switch pair for each control bit.
    for (genvar j = 0; j < HALF; j++) begin : g_pair
        localparam int LO = (j / DIST) * 2 * DIST + (j % DIST);
        localparam int HI = LO + DIST;
        assign stg_out[LO] = swap[j] ? stg_in[HI] : stg_in[LO];
        assign stg_out[HI] = swap[j] ? stg_in[LO] : stg_in[HI];
    end

    // Checks that the row only moves bits and that zero control is the identity.
    always_comb begin
        p_ones_kept_r9: assert ($countones(stg_out) == $countones(stg_in))
            else $error("stage changed the number of ones");
        if (swap == '0) begin
            p_zero_identity_r4: assert (stg_out == stg_in)
                else $error("zero control altered the word");
        end
    end

endmodule

// File: rtl/bfperm_net.sv
// Module: a full lg(WIDTH)-stage network.
// INVERSE = 0 builds the forward network, with distances WIDTH/2 down to 1.
// INVERSE = 1 builds the mirrored network, with distances 1 up to WIDTH/2.
// Stage s reads slice s of cfg, which is bits (s-1)*WIDTH/2 up to s*WIDTH/2-1.
// Purely combinational.
module bfperm_net #(
    parameter int WIDTH   = 32,
    parameter bit INVERSE = 1'b0
) (
    input  logic [WIDTH-1:0]                      net_in,
    input  logic [$clog2(WIDTH)*(WIDTH/2)-1:0]    cfg,
    output logic [WIDTH-1:0]                      net_out
);

    localparam int LG   = $clog2(WIDTH);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] tap [0:LG];
    logic [WIDTH-1:0] in_rev;

    assign tap[0]  = net_in;
    assign net_out = tap[LG];

    // Chain of stages; the variant picks the distance order.
    for (genvar s = 1; s <= LG; s++) begin : g_stage
        localparam int DIST = INVERSE ? (1 << (s - 1)) : (WIDTH >> s);
        bfperm_stage #(
            .WIDTH (WIDTH),
            .DIST  (DIST)
        ) u_stage (
            .stg_in  (tap[s-1]),
            .swap    (cfg[(s-1)*HALF +: HALF]),
            .stg_out (tap[s])
        );
    end

    // End-to-end reversal of the input, used by the all-swap check.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign in_rev[i] = net_in[WIDTH-1-i];
    end

    // Checks that swapping every pair reverses the word (R1; R2 for the inverse variant).
    always_comb begin
        if (&cfg) begin
            p_all_swap_reverse_r1: assert (net_out == in_rev)
                else $error("all-swap control did not reverse the word");
        end
    end

endmodule

// File: rtl/bfperm_unit.sv
// Module: butterfly / inverse butterfly permuter, top level.
// The forward network always sees data_in. The inverse network sees
// the forward result in series mode and data_in otherwise. The
// selected result is registered when in_valid is high.
// Assumes WIDTH is a power of two, at least 2. Synchronous active-low reset.
module bfperm_unit
    import bfperm_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [1:0]                             op,
    input  logic [WIDTH-1:0]                       data_in,
    input  logic [$clog2(WIDTH)*(WIDTH/2)-1:0]     fwd_cfg,
    input  logic [$clog2(WIDTH)*(WIDTH/2)-1:0]     inv_cfg,
    output logic                                   out_valid,
    output logic [WIDTH-1:0]                       data_out
);

    localparam int LG    = $clog2(WIDTH);
    localparam int HALF  = WIDTH / 2;
    localparam int CFG_W = LG * HALF;

    perm_op_e         op_sel;
    logic [WIDTH-1:0] fwd_res;
    logic [WIDTH-1:0] inv_src;
    logic [WIDTH-1:0] inv_res;
    logic [WIDTH-1:0] result;
    logic [CFG_W-1:0] fwd_mirror;

    assign op_sel = perm_op_e'(op);

    // Forward network on the raw input.
    bfperm_net #(
        .WIDTH   (WIDTH),
        .INVERSE (1'b0)
    ) u_fwd (
        .net_in  (data_in),
        .cfg     (fwd_cfg),
        .net_out (fwd_res)
    );

    // Inverse network source: the forward result only in series mode.
    assign inv_src = (op_sel == OP_BOTH) ? fwd_res : data_in;

    bfperm_net #(
        .WIDTH   (WIDTH),
        .INVERSE (1'b1)
    ) u_inv (
        .net_in  (inv_src),
        .cfg     (inv_cfg),
        .net_out (inv_res)
    );

    // Result select by opcode.
    always_comb begin
        case (op_sel)
            OP_FWD:  result = fwd_res;
            OP_INV:  result = inv_res;
            OP_BOTH: result = inv_res;
            default: result = data_in;
        endcase
    end

    // Output register and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                data_out <= result;
            end
        end
    end

    // Forward control with its slices in reverse order, used only by the undo check.
    for (genvar s = 0; s < LG; s++) begin : g_mirror
        assign fwd_mirror[s*HALF +: HALF] = fwd_cfg[(LG-1-s)*HALF +: HALF];
    end

    p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(data_out));

    p_pass_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11) |=> data_out == $past(data_in));

    p_zero_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fwd_cfg == '0 && inv_cfg == '0) |=> data_out == $past(data_in));

    p_mirror_undo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b10 && inv_cfg == fwd_mirror) |=> data_out == $past(data_in));

    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && data_out == '0));

endmodule

// File: tb/test_bfperm_unit.sv
// Directed bench for bfperm_unit at WIDTH = 16.
module test_bfperm_unit;

    localparam int W     = 16;
    localparam int LG    = 4;
    localparam int H     = W / 2;
    localparam int CFG_W = LG * H;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [1:0]       op = 2'b00;
    logic [W-1:0]     data_in = '0;
    logic [CFG_W-1:0] fwd_cfg = '0;
    logic [CFG_W-1:0] inv_cfg = '0;
    logic             out_valid;
    logic [W-1:0]     data_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    bfperm_unit #(.WIDTH(W)) i_bfperm_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .data_in   (data_in),
        .fwd_cfg   (fwd_cfg),
        .inv_cfg   (inv_cfg),
        .out_valid (out_valid),
        .data_out  (data_out)
    );

    // Reference: one stage written per output bit, from the pairing rule.
    function automatic logic [W-1:0] ref_stage(logic [W-1:0] x, logic [H-1:0] c, int d);
        logic [W-1:0] y;
        for (int i = 0; i < W; i++) begin
            int lo = i & ~d;
            int j  = (lo / (2 * d)) * d + (lo % d);
            y[i] = c[j] ? x[i ^ d] : x[i];
        end
        return y;
    endfunction

    function automatic logic [W-1:0] ref_fwd(logic [W-1:0] x, logic [CFG_W-1:0] c);
        logic [W-1:0] y = x;
        for (int s = 1; s <= LG; s++) y = ref_stage(y, c[(s-1)*H +: H], W >> s);
        return y;
    endfunction

    function automatic logic [W-1:0] ref_inv(logic [W-1:0] x, logic [CFG_W-1:0] c);
        logic [W-1:0] y = x;
        for (int s = 1; s <= LG; s++) y = ref_stage(y, c[(s-1)*H +: H], 1 << (s - 1));
        return y;
    endfunction

    function automatic logic [CFG_W-1:0] mirror(logic [CFG_W-1:0] c);
        logic [CFG_W-1:0] m;
        for (int s = 0; s < LG; s++) m[s*H +: H] = c[(LG-1-s)*H +: H];
        return m;
    endfunction

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one request at a falling edge; the result is registered by the next falling edge.
    task automatic send(logic [1:0] o, logic [W-1:0] d, logic [CFG_W-1:0] fc, logic [CFG_W-1:0] ic);
        @(negedge clk);
        op = o; data_in = d; fwd_cfg = fc; inv_cfg = ic; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R8 reset data_out", data_out, '0);
        check("R8 reset out_valid", W'(out_valid), '0);
    endtask

    task automatic t_fwd_bits();
        for (int b = 0; b < CFG_W; b++) begin
            logic [W-1:0] d = 16'hA5C3 ^ W'(b * 16'h1357);
            send(2'b00, d, CFG_W'(1) << b, '0);
            check($sformatf("R1 fwd bit %0d", b), data_out, ref_fwd(d, CFG_W'(1) << b));
        end
        send(2'b00, 16'h1234, '1, '0);
        check("R1 all ones reverse", data_out, {<<{16'h1234}});
    endtask

    task automatic t_inv_bits();
        for (int b = 0; b < CFG_W; b++) begin
            logic [W-1:0] d = 16'h3C96 ^ W'(b * 16'h0F0F);
            send(2'b01, d, '0, CFG_W'(1) << b);
            check($sformatf("R2 inv bit %0d", b), data_out, ref_inv(d, CFG_W'(1) << b));
        end
        send(2'b01, 16'h8001, '0, '1);
        check("R2 all ones reverse", data_out, {<<{16'h8001}});
    endtask

    task automatic t_ops();
        for (int k = 0; k < 40; k++) begin
            logic [W-1:0]     d  = W'($urandom);
            logic [CFG_W-1:0] fc = CFG_W'($urandom);
            logic [CFG_W-1:0] ic = CFG_W'($urandom);
            send(2'b10, d, fc, ic);
            check("R3 series", data_out, ref_inv(ref_fwd(d, fc), ic));
            check("R9 ones count", W'($countones(data_out)), W'($countones(d)));
            send(2'b11, d, fc, ic);
            check("R3 pass", data_out, d);
            send(2'b00, d, fc, ic);
            check("R3 fwd only", data_out, ref_fwd(d, fc));
            send(2'b01, d, fc, ic);
            check("R3 inv only", data_out, ref_inv(d, ic));
        end
    endtask

    task automatic t_zero_cfg();
        for (int o = 0; o < 4; o++) begin
            send(2'(o), 16'hBEEF, '0, '0);
            check($sformatf("R4 zero cfg op %0d", o), data_out, 16'hBEEF);
        end
    endtask

    task automatic t_mirror();
        for (int k = 0; k < 20; k++) begin
            logic [W-1:0]     d  = W'($urandom);
            logic [CFG_W-1:0] fc = CFG_W'($urandom);
            send(2'b10, d, fc, mirror(fc));
            check("R5 mirror undo", data_out, d);
        end
    endtask

    task automatic t_timing();
        @(negedge clk);
        op = 2'b11; data_in = 16'h0F0F; in_valid = 1'b1;
        #1;
        check("R6 not yet valid", W'(out_valid), '0);
        check("R6 not yet loaded", data_out == 16'h0F0F ? '1 : '0, '0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 valid after edge", W'(out_valid), W'(1));
        check("R6 data after edge", data_out, 16'h0F0F);
        @(negedge clk);
        check("R6 valid drops", W'(out_valid), '0);
    endtask

    task automatic t_hold();
        send(2'b11, 16'h5AA5, '0, '0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            op = 2'(k); data_in = W'($urandom); fwd_cfg = CFG_W'($urandom);
            @(negedge clk);
            check("R7 hold idle", data_out, 16'h5AA5);
        end
    endtask

    task automatic t_reset_mid();
        send(2'b11, 16'hFFFF, '0, '0);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; data_in = 16'h7777;
        @(negedge clk);
        check("R8 mid reset data", data_out, '0);
        check("R8 mid reset valid", W'(out_valid), '0);
        in_valid = 1'b0; rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_fwd_bits();
        t_inv_bits();
        t_ops();
        t_zero_cfg();
        t_mirror();
        t_timing();
        t_hold();
        t_reset_mid();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule